// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with Write Control

This block is an 8-bit down-counter with a reload register, driven by a one-cycle tick enable. Software reaches it through a small register interface. The interface holds four things:

- a control byte with the run flag, a write-control bit, an edge-polarity bit and a mode bit;
- a count register, used both to write the count value and to read the live counter;
- a waveform control register;
- a status register holding the external-input interrupt flag.

While running, each tick lowers the counter by one. A tick that finds the counter at 00h reloads it from the reload register and raises an underflow interrupt for one clock.

The write-control bit decides what a count write does while the timer runs. With the bit clear, the write updates both the reload register and the counter. With the bit set, the write updates only the reload register, and the running count carries on undisturbed. While the timer is stopped, a count write always loads both. Software can therefore either retarget the live count at once or change only the next period.

Only timer mode is implemented. A separate edge detector watches an external input and sets a sticky interrupt flag on the edge chosen by the polarity bit. That flag can be set falsely when the polarity bit changes, so software clears it after changing the polarity.

Top module: `tmr_reload_top`

## Requirements
- R1: After reset the control register (address 0) reads 00h, the count register (address 1) reads 00h, the status register (address 3) reads 00h, and `irq_o` and `ext_irq_o` are low.
- R2: Control bit 0 is the run flag. With it set (and bit 3 clear), each cycle with `tick_i` high decrements the counter. With it clear, ticks leave the counter unchanged.
- R3: A tick that finds the counter at 00h reloads the counter from the reload register. The same clock edge sets `irq_o`, which is high for the cycle that follows that tick.
- R4: While running with control bit 1 (write control) clear, a write to address 1 loads both the counter and the reload register with the written value.
- R5: While running with control bit 1 set, a write to address 1 loads only the reload register. The counter keeps counting from its current value, and the new value is used at the next underflow.
- R6: While the run flag is clear, a write to address 1 loads both the counter and the reload register, whatever control bit 1 holds.
- R7: A read of address 1 returns the live counter value, not the reload register.
- R8: Control bit 2 selects the active edge of `ext_i`: 0 means rising, 1 means falling. The active edge sets status bit 0, which also drives `ext_irq_o`. Writing status bit 0 with a 1 clears the flag; a set in the same cycle takes precedence over the clear.
- R9: Changing control bit 2 while `ext_i` holds a level can set status bit 0 even though `ext_i` has no edge. For example, going from rising to falling with `ext_i` low sets the flag.
- R10: In the waveform control register (address 2), bits 3:0 always read 0. Bits 7:4 are stored and read back, and they have no effect on the counter or on `irq_o`.
- R11: Control bit 3 is the mode bit, and 0 selects timer mode. With it set, the counter does not count, even with the run flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| ext_i | input | 1 | External input, synchronous to clk_i |
| irq_o | output | 1 | Underflow interrupt pulse |
| ext_irq_o | output | 1 | External-input interrupt flag |

## Verification
The bench checks the write-control matrix:

- A reload-only write made while running must leave the counter where it was. A design that ignored the write-control bit would jump straight to the new value.
- A write made while stopped with write control set must still load the counter. A design that applied the bit regardless of the run flag would leave a stale count.

The bench also counts down through 00h and checks that the reload value and a single-cycle `irq_o` appear exactly one cycle after the tick. An off-by-one design would reload at 01h or stretch the pulse.

On the edge detector, the bench changes the polarity bit with the input held low and expects the false flag set. It also checks that a rising edge does not count once falling polarity is selected. Finally, it writes all ones to the waveform register and expects the low nibble to read 0 while the count stays still.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned RSV_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_WAVE  = 2'd2,
    A_STAT  = 2'd3
  } reg_addr_e;

  // bit3 mode, bit2 edge polarity, bit1 write control, bit0 run
  typedef struct packed {
    logic mode_alt;
    logic edge_fall;
    logic wr_reload_only;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic              ext_flag_i,
  output ctrl_t             ctrl_o,
  output logic              cnt_wr_o,
  output logic              flag_clr_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int unsigned WAVE_W = DW - RSV_W;

  ctrl_t             ctrl_q;
  logic [WAVE_W-1:0] wave_q;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      wave_q <= '0;
    end else if (we_i) begin
      if (addr == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr == A_WAVE) wave_q <= wdata_i[DW-1:RSV_W];
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cnt_wr_o   = we_i && (addr == A_COUNT);
  assign flag_clr_o = we_i && (addr == A_STAT) && wdata_i[0];

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      A_COUNT: rdata_o = cnt_i;
      A_WAVE:  rdata_o = {wave_q, {RSV_W{1'b0}}};
      default: rdata_o = {{(DW-1){1'b0}}, ext_flag_i};
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          count_en_i,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic          wr_cnt_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt_q, rld_q;
  logic          irq_q;
  logic          step, under;

  assign step  = count_en_i && tick_i;
  assign under = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= under;
      if (wr_i) rld_q <= wdata_i;
      // a direct counter load takes precedence over a same-cycle tick
      if (wr_i && wr_cnt_i) cnt_q <= wdata_i;
      else if (under)       cnt_q <= rld_q;
      else if (step)        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic fall_i,
  input  logic clr_i,
  output logic flag_o
);
  logic lvl, lvl_q, flag_q;

  // polarity folded into the level, so a polarity change looks like an edge
  assign lvl = ext_i ^ fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (lvl && !lvl_q) flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_reload_top.sv
module tmr_reload_top
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              tick_i,
  input  logic              ext_i,
  output logic              irq_o,
  output logic              ext_irq_o
);
  ctrl_t         ctrl;
  logic          run, wr_reload_only, mode_alt, count_en;
  logic          cnt_wr, flag_clr, ext_flag, wr_cnt;
  logic [DW-1:0] cnt_q, rld_q;

  assign run            = ctrl.run;
  assign wr_reload_only = ctrl.wr_reload_only;
  assign mode_alt       = ctrl.mode_alt;
  assign count_en       = run && !mode_alt;
  // write control only matters while running
  assign wr_cnt         = !(run && wr_reload_only);

  tmr_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cnt_i      (cnt_q),
    .ext_flag_i (ext_flag),
    .ctrl_o     (ctrl),
    .cnt_wr_o   (cnt_wr),
    .flag_clr_o (flag_clr),
    .rdata_o    (reg_rdata_o)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_en_i (count_en),
    .tick_i     (tick_i),
    .wr_i       (cnt_wr),
    .wr_cnt_i   (wr_cnt),
    .wdata_i    (reg_wdata_i),
    .cnt_o      (cnt_q),
    .rld_o      (rld_q),
    .irq_o      (irq_o)
  );

  tmr_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_i),
    .fall_i (ctrl.edge_fall),
    .clr_i  (flag_clr),
    .flag_o (ext_flag)
  );

  assign ext_irq_o = ext_flag;
endmodule

// File: rtl/tmr_reload_chk.sv
module tmr_reload_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          tick_i,
  input logic          run,
  input logic          wr_reload_only,
  input logic          mode_alt,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] rld_q,
  input logic          irq_o
);
  logic cnt_write;
  assign cnt_write = reg_we_i && (reg_addr_i == 2'd1);

  a_r2_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_write) |=> $stable(cnt_q));

  a_r2_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !mode_alt && tick_i && !cnt_write && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r3_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(tick_i) && $past(run) && $past(cnt_q) == '0));

  a_r4_run_write_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_write && run && !wr_reload_only) |=> (cnt_q == $past(reg_wdata_i) && rld_q == $past(reg_wdata_i)));

  a_r5_reload_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_write && run && wr_reload_only && !tick_i) |=> ($stable(cnt_q) && rld_q == $past(reg_wdata_i)));

  a_r6_stop_write_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_write && !run) |=> (cnt_q == $past(reg_wdata_i) && rld_q == $past(reg_wdata_i)));

  a_r10_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd2) |-> (reg_rdata_o[3:0] == 4'h0));

  a_r11_mode_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_alt && !cnt_write) |=> $stable(cnt_q));
endmodule

bind tmr_reload_top tmr_reload_chk #(.DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .tick_i         (tick_i),
  .run            (run),
  .wr_reload_only (wr_reload_only),
  .mode_alt       (mode_alt),
  .cnt_q          (cnt_q),
  .rld_q          (rld_q),
  .irq_o          (irq_o)
);

// File: tb/tb_tmr_reload_top.sv
module tb_tmr_reload_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       tick_i = 1'b0;
  logic       ext_i = 1'b0;
  logic       irq_o, ext_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  tmr_reload_top dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .tick_i      (tick_i),
    .ext_i       (ext_i),
    .irq_o       (irq_o),
    .ext_irq_o   (ext_irq_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // one tick; returns irq_o sampled the cycle after the tick
  task automatic tick1(output logic irq);
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    irq = irq_o;
  endtask

  task automatic ticks(input int n);
    logic unused_irq;
    for (int i = 0; i < n; i++) tick1(unused_irq);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 count", d, 8'h00);
    rd(2'd3, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 ext_irq", {7'd0, ext_irq_o}, 8'h00);
  endtask

  task automatic t_stopped_write();
    logic [7:0] d;
    wr(2'd0, 8'h02);                 // stopped, write control set
    wr(2'd1, 8'h05);
    rd(2'd1, d); chk("R6 stopped write loads counter", d, 8'h05);
    ticks(3);
    rd(2'd1, d); chk("R2 stopped holds", d, 8'h05);
  endtask

  task automatic t_count_underflow();
    logic [7:0] d;
    logic irq;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h01);                 // run
    ticks(1);
    rd(2'd1, d); chk("R2 R7 decrement", d, 8'h01);
    tick1(irq);
    rd(2'd1, d); chk("R3 reaches zero", d, 8'h00);
    chk("R3 no irq before underflow", {7'd0, irq}, 8'h00);
    tick1(irq);
    rd(2'd1, d); chk("R3 reload", d, 8'h02);
    chk("R3 irq pulse", {7'd0, irq}, 8'h01);
    @(negedge clk_i);
    chk("R3 irq one cycle", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_run_write_both();
    logic [7:0] d;
    logic irq;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03);
    rd(2'd1, d); chk("R4 running write loads counter", d, 8'h03);
    ticks(4);
    rd(2'd1, d); chk("R4 reload value used", d, 8'h03);
    tick1(irq);
    rd(2'd1, d); chk("R4 continues", d, 8'h02);
  endtask

  task automatic t_reload_only();
    logic [7:0] d;
    logic irq;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h03);                 // run, reload only
    ticks(1);
    rd(2'd1, d); chk("R5 pre", d, 8'h03);
    wr(2'd1, 8'h07);
    rd(2'd1, d); chk("R5 counter undisturbed", d, 8'h03);
    ticks(3);
    rd(2'd1, d); chk("R5 counts down", d, 8'h00);
    tick1(irq);
    rd(2'd1, d); chk("R5 new reload at underflow", d, 8'h07);
    chk("R5 irq", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h06);
    wr(2'd0, 8'h09);                 // run with mode bit set
    ticks(2);
    rd(2'd1, d); chk("R11 non-timer mode holds", d, 8'h06);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    @(negedge clk_i); ext_i = 1'b1;
    @(negedge clk_i);
    rd(2'd3, d); chk("R8 rising sets flag", d, 8'h01);
    chk("R8 ext_irq", {7'd0, ext_irq_o}, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd3, d); chk("R8 clear", d, 8'h00);
    @(negedge clk_i); ext_i = 1'b0;
    @(negedge clk_i);
    rd(2'd3, d); chk("R8 falling ignored when rising", d, 8'h00);
    wr(2'd0, 8'h04);                 // falling polarity, input low
    @(negedge clk_i);
    rd(2'd3, d); chk("R9 polarity change false set", d, 8'h01);
    wr(2'd3, 8'h01);
    @(negedge clk_i); ext_i = 1'b1;
    @(negedge clk_i);
    rd(2'd3, d); chk("R8 rising ignored when falling", d, 8'h00);
    @(negedge clk_i); ext_i = 1'b0;
    @(negedge clk_i);
    rd(2'd3, d); chk("R8 falling sets flag", d, 8'h01);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_wave();
    logic [7:0] d;
    logic [7:0] c0;
    wr(2'd0, 8'h00);
    rd(2'd1, c0);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R10 reserved low bits zero", d, 8'hF0);
    rd(2'd1, d); chk("R10 no effect on counter", d, c0);
    chk("R10 no irq", {7'd0, irq_o}, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_stopped_write();
        t_count_underflow();
        t_run_write_both();
        t_reload_only();
        t_mode();
        t_ext();
        t_wave();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule